// File: doc/BRIEF.md
# Graphics Vertical Delay Register Bank

This block keeps the two 8-bit player bitmap registers and the 1-bit ball enable of a small video generator, each paired with a shadow copy used to shift the object down by one scan line. Software writes bitmaps and enables through a 6-bit address, 8-bit data bus and a write strobe. Every object also has a select bit. This bit chooses whether the output shows the live (main) value or the shadow value.

Shadow copies are never written directly. A write to one player's bitmap makes the other player's shadow capture that other player's main value as it stood before the edge. A write to player 1 also moves the ball's main enable into the ball shadow. Software that writes player 0 and player 1 on alternate lines therefore gets a one-line-delayed version of each object for free. The outputs are combinational multiplexers over the stored state. Positioning, serialisation and collision detection belong to other blocks.

Top module: `gfx_vdelay_bank`

## Requirements
- R1: A write to address 0x1B loads the whole data byte into the player 0 main register.
- R2: A write to address 0x1C loads the whole data byte into the player 1 main register.
- R3: A write to 0x1B copies the player 1 main value, as it was before that edge, into the player 1 shadow.
- R4: A write to 0x1C copies the pre-edge player 0 main value into the player 0 shadow and the pre-edge ball main enable into the ball shadow.
- R5: A write to 0x1F loads data bit 1 into the ball main enable and leaves the ball shadow unchanged.
- R6: Writes to 0x25, 0x26 and 0x27 load data bit 0 into the select bit of player 0, player 1 and the ball respectively. A select value of 1 routes the shadow copy to that object's output, and 0 routes the main copy.
- R7: With the write strobe low, or with an address other than the six listed, no stored value changes.
- R8: A synchronous active-high reset clears every main, shadow and select bit to zero, so all outputs read zero.
- R9: For the sequence player 0, player 1, player 0 writes, each shadow holds the main value that stood immediately before the write that loaded it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Register address |
| wr_data | input | 8 | Write data |
| pat0_out | output | 8 | Selected player 0 bitmap |
| pat1_out | output | 8 | Selected player 1 bitmap |
| ball_out | output | 1 | Selected ball enable |

## Verification
The assertions assume that `wr_en`, `wr_addr` and `wr_data` are stable around each rising edge, and that reset lasts at least one edge before any write is checked. The stimulus changes inputs only on falling edges and holds reset for several cycles. The random phase draws addresses mostly from the six decoded locations, with a share of unused addresses and idle strobe cycles, so that the cross-copy and ignore cases all occur.

// File: rtl/gvd_pkg.sv
package gvd_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int NUM_PLAYERS = 2;
  localparam int NUM_SEL = NUM_PLAYERS + 1;
  localparam int BALL_BIT = 1;
  localparam int SEL_BIT = 0;

  localparam logic [ADDR_W-1:0] A_PLAYER0 = 6'h1B;
  localparam logic [ADDR_W-1:0] A_PLAYER1 = 6'h1C;
  localparam logic [ADDR_W-1:0] A_BALL    = 6'h1F;
  localparam logic [ADDR_W-1:0] A_SEL0    = 6'h25;

  typedef struct packed {
    logic [NUM_PLAYERS-1:0] player;
    logic                   ball;
    logic [NUM_SEL-1:0]     sel;
  } gvd_hits_t;
endpackage

// File: rtl/gvd_decode.sv
module gvd_decode
  import gvd_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output gvd_hits_t     hits
);
  always_comb begin
    hits = '0;
    if (wr_en) begin
      hits.player[0] = (wr_addr == A_PLAYER0);
      hits.player[1] = (wr_addr == A_PLAYER1);
      hits.ball      = (wr_addr == A_BALL);
      for (int k = 0; k < NUM_SEL; k++) begin
        hits.sel[k] = (wr_addr == AW'(int'(A_SEL0) + k));
      end
    end
  end
endmodule

// File: rtl/gvd_players.sv
module gvd_players
  import gvd_pkg::*;
#(
  parameter int NP = NUM_PLAYERS,
  parameter int DW = DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NP-1:0]         hit,
  input  logic [DW-1:0]         wr_data,
  input  logic [NP-1:0]         sel,
  output logic [NP-1:0][DW-1:0] main_q,
  output logic [NP-1:0][DW-1:0] shadow_q,
  output logic [NP-1:0][DW-1:0] pat
);
  for (genvar i = 0; i < NP; i++) begin : g_obj
    localparam int PARTNER = NP - 1 - i;

    always_ff @(posedge clk) begin
      if (rst) begin
        main_q[i]   <= '0;
        shadow_q[i] <= '0;
      end else begin
        if (hit[i]) main_q[i] <= wr_data;
        // partner write captures this object's pre-edge main value
        if (hit[PARTNER]) shadow_q[i] <= main_q[i];
      end
    end

    assign pat[i] = sel[i] ? shadow_q[i] : main_q[i];
  end
endmodule

// File: rtl/gvd_ball.sv
module gvd_ball (
  input  logic clk,
  input  logic rst,
  input  logic hit_ball,
  input  logic hit_p1,
  input  logic data_bit,
  input  logic sel,
  output logic main_q,
  output logic shadow_q,
  output logic ball
);
  always_ff @(posedge clk) begin
    if (rst) begin
      main_q   <= 1'b0;
      shadow_q <= 1'b0;
    end else begin
      if (hit_ball) main_q <= data_bit;
      if (hit_p1) shadow_q <= main_q;
    end
  end

  assign ball = sel ? shadow_q : main_q;
endmodule

// File: rtl/gvd_select.sv
module gvd_select #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit,
  input  logic         data_bit,
  output logic [N-1:0] sel_q
);
  for (genvar k = 0; k < N; k++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst) sel_q[k] <= 1'b0;
      else if (hit[k]) sel_q[k] <= data_bit;
    end
  end
endmodule

// File: rtl/gfx_vdelay_bank.sv
module gfx_vdelay_bank
  import gvd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] pat0_out,
  output logic [DATA_W-1:0] pat1_out,
  output logic              ball_out
);
  gvd_hits_t hits;
  logic [NUM_SEL-1:0] sel_q;
  logic [NUM_PLAYERS-1:0][DATA_W-1:0] main_q, shadow_q, pat;
  logic ball_main_q, ball_shadow_q;

  gvd_decode #(.AW(ADDR_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .hits(hits)
  );

  gvd_select #(.N(NUM_SEL)) u_sel (
    .clk(clk), .rst(rst), .hit(hits.sel),
    .data_bit(wr_data[SEL_BIT]), .sel_q(sel_q)
  );

  gvd_players #(.NP(NUM_PLAYERS), .DW(DATA_W)) u_players (
    .clk(clk), .rst(rst), .hit(hits.player), .wr_data(wr_data),
    .sel(sel_q[NUM_PLAYERS-1:0]), .main_q(main_q), .shadow_q(shadow_q),
    .pat(pat)
  );

  gvd_ball u_ball (
    .clk(clk), .rst(rst), .hit_ball(hits.ball), .hit_p1(hits.player[1]),
    .data_bit(wr_data[BALL_BIT]), .sel(sel_q[NUM_SEL-1]),
    .main_q(ball_main_q), .shadow_q(ball_shadow_q), .ball(ball_out)
  );

  assign pat0_out = pat[0];
  assign pat1_out = pat[1];
endmodule

// File: rtl/gvd_checker.sv
module gvd_checker
  import gvd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] m0,
  input logic [DATA_W-1:0] m1,
  input logic [DATA_W-1:0] s0,
  input logic [DATA_W-1:0] s1,
  input logic              bm,
  input logic              bs,
  input logic [NUM_SEL-1:0] sel
);
  logic w_p0, w_p1, w_ball, w_s0;
  assign w_p0   = wr_en && wr_addr == A_PLAYER0;
  assign w_p1   = wr_en && wr_addr == A_PLAYER1;
  assign w_ball = wr_en && wr_addr == A_BALL;
  assign w_s0   = wr_en && wr_addr == A_SEL0;

  AST_P0_MAIN_LOAD: assert property (@(posedge clk) disable iff (rst)
    w_p0 |=> m0 == $past(wr_data)); // R1
  AST_P1_MAIN_LOAD: assert property (@(posedge clk) disable iff (rst)
    w_p1 |=> m1 == $past(wr_data)); // R2
  AST_P1_SHADOW_CROSS: assert property (@(posedge clk) disable iff (rst)
    w_p0 |=> s1 == $past(m1)); // R3
  AST_P0_SHADOW_CROSS: assert property (@(posedge clk) disable iff (rst)
    w_p1 |=> s0 == $past(m0)); // R4
  AST_BALL_SHADOW_CROSS: assert property (@(posedge clk) disable iff (rst)
    w_p1 |=> bs == $past(bm)); // R4
  AST_BALL_MAIN_ONLY: assert property (@(posedge clk) disable iff (rst)
    w_ball |=> (bm == $past(wr_data[BALL_BIT])) && $stable(bs)); // R5
  AST_SEL0_LOAD: assert property (@(posedge clk) disable iff (rst)
    w_s0 |=> sel[0] == $past(wr_data[SEL_BIT])); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(m0) && $stable(m1) && $stable(s0) && $stable(s1)
               && $stable(bm) && $stable(bs) && $stable(sel)); // R7
endmodule

bind gfx_vdelay_bank gvd_checker u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .m0(u_players.main_q[0]), .m1(u_players.main_q[1]),
  .s0(u_players.shadow_q[0]), .s1(u_players.shadow_q[1]),
  .bm(u_ball.main_q), .bs(u_ball.shadow_q), .sel(u_sel.sel_q)
);

// File: tb/gfx_vdelay_bank_tb.sv
`timescale 1ns/1ps
module gfx_vdelay_bank_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] pat0_out, pat1_out;
  logic ball_out;

  int checks = 0;
  int errors = 0;
  string phase = "R8";

  // behavioural reference state
  int rm0, rm1, rs0, rs1, rbm, rbs;
  int rsel [3];

  gfx_vdelay_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pat0_out(pat0_out), .pat1_out(pat1_out), .ball_out(ball_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference update: every rule applied against pre-edge values
  always @(posedge clk) begin
    int n0, n1, ns0, ns1, nbm, nbs;
    n0 = rm0; n1 = rm1; ns0 = rs0; ns1 = rs1; nbm = rbm; nbs = rbs;
    if (rst) begin
      n0 = 0; n1 = 0; ns0 = 0; ns1 = 0; nbm = 0; nbs = 0;
      foreach (rsel[k]) rsel[k] = 0;
    end else if (wr_en) begin
      case (wr_addr)
        6'h1B: begin n0 = wr_data; ns1 = rm1; end
        6'h1C: begin n1 = wr_data; ns0 = rm0; nbs = rbm; end
        6'h1F: nbm = wr_data[1];
        6'h25: rsel[0] = wr_data[0];
        6'h26: rsel[1] = wr_data[0];
        6'h27: rsel[2] = wr_data[0];
        default: ;
      endcase
    end
    rm0 = n0; rm1 = n1; rs0 = ns0; rs1 = ns1; rbm = nbm; rbs = nbs;
    #2;
    if (!rst) begin
      chk({phase, " pat0"}, pat0_out, rsel[0] ? rs0 : rm0);
      chk({phase, " pat1"}, pat1_out, rsel[1] ? rs1 : rm1);
      chk({phase, " ball"}, ball_out, rsel[2] ? rbs : rbm);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    rm0 = 0; rm1 = 0; rs0 = 0; rs1 = 0; rbm = 0; rbs = 0;
    foreach (rsel[k]) rsel[k] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset pat0", pat0_out, 0);
    chk("R8 reset pat1", pat1_out, 0);
    chk("R8 reset ball", ball_out, 0);

    phase = "R1"; wr(6'h1B, 8'hA5); chk("R1 p0 main", pat0_out, 8'hA5);
    phase = "R2"; wr(6'h1C, 8'h3C); chk("R2 p1 main", pat1_out, 8'h3C);
    phase = "R4"; wr(6'h25, 8'h01); chk("R4 p0 shadow", pat0_out, 8'hA5);
    phase = "R3"; wr(6'h1B, 8'h11); chk("R3 p0 shows shadow", pat0_out, 8'hA5);
    wr(6'h26, 8'h01); chk("R3 p1 shadow", pat1_out, 8'h3C);
    phase = "R9"; wr(6'h1C, 8'h77);
    chk("R9 p0 shadow prior main", pat0_out, 8'h11);
    chk("R9 p1 shadow unchanged", pat1_out, 8'h3C);
    wr(6'h1B, 8'h99); chk("R9 p1 shadow prior main", pat1_out, 8'h77);
    phase = "R6"; wr(6'h25, 8'hFE); chk("R6 sel0 bit0 clear", pat0_out, 8'h99);
    phase = "R5"; wr(6'h1F, 8'h02); chk("R5 ball main", ball_out, 1);
    wr(6'h27, 8'h01); chk("R5 ball shadow untouched", ball_out, 0);
    phase = "R4"; wr(6'h1C, 8'h00); chk("R4 ball shadow copy", ball_out, 1);
    phase = "R5"; wr(6'h1F, 8'hFD); chk("R5 bit1 only", ball_out, 1);
    wr(6'h27, 8'h00); chk("R5 ball main cleared", ball_out, 0);
    phase = "R7";
    wr(6'h1D, 8'hFF); wr(6'h24, 8'hFF); wr(6'h3F, 8'hFF);
    wr_addr = 6'h1B; wr_data = 8'hFF; @(negedge clk);
    chk("R7 p0 unchanged", pat0_out, 8'h99);
    chk("R7 ball unchanged", ball_out, 0);

    phase = "R9 random";
    for (int i = 0; i < 3000; i++) begin
      int pick;
      logic [5:0] a;
      pick = $urandom_range(0, 9);
      case (pick)
        0: a = 6'h1B; 1, 2: a = 6'h1C; 3: a = 6'h1F; 4: a = 6'h1B;
        5: a = 6'h25 + 6'($urandom_range(0, 2));
        6: a = 6'($urandom);
        default: a = 6'h1C;
      endcase
      wr_en = ($urandom_range(0, 4) != 0); wr_addr = a; wr_data = 8'($urandom);
      @(negedge clk);
    end
    wr_en = 1'b0;
    phase = "R8";
    rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0; @(negedge clk);
    chk("R8 mid reset pat0", pat0_out, 0);
    chk("R8 mid reset pat1", pat1_out, 0);
    chk("R8 mid reset ball", ball_out, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule